// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filtering

This block receives asynchronous serial frames on one input line. It oversamples the line with a baud tick running at sixteen times the bit rate, confirms each start bit at mid-bit and shifts in eight or nine data bits, least significant first. It then samples one stop bit. A control input selects eight or nine data bits. The ninth bit is passed to the host unchanged. The block computes no parity, so the host may use the ninth bit as a parity bit or as an address marker.

Finished words go into a two-entry holding buffer. Each entry keeps the data byte, the ninth bit and a framing-error bit. The host sees the oldest entry on the output pins and removes it with a one-cycle read strobe. In multi-drop systems an address-filter mode can be enabled. In nine-bit operation it drops every frame whose ninth bit is clear, so a listening node only wakes up on address frames. The block flags overrun when a word arrives while the buffer is full. That flag stays set until continuous reception is switched off.

Top module: `nbit_uart_rx`

## Requirements
- R1: After reset, data_ready, rd_data, rd_bit9, framing_err and overrun_err are all 0.
- R2: With nine_bit_en = 0, a frame has one low start bit, eight data bits sent least significant bit first and one stop bit. A complete frame is stored with rd_bit9 = 0.
- R3: With nine_bit_en = 1, a ninth bit follows the eight data bits and appears unchanged on rd_bit9. It is not checked as parity.
- R4: With nine_bit_en = 1 and addr_det_en = 1, a frame whose ninth bit is 0 is discarded and leaves the buffer unchanged. A frame whose ninth bit is 1 is stored.
- R5: With addr_det_en = 0, every frame is stored whatever its ninth bit.
- R6: With nine_bit_en = 0, addr_det_en has no effect and every eight-bit frame is stored.
- R7: While port_en = 0 or cont_rx_en = 0, the receiver stays idle and stores no frame.
- R8: A low pulse on the line shorter than half a bit is not taken as a start bit. A valid frame that follows it is received correctly.
- R9: A frame whose stop bit samples low is still stored, with its framing-error bit set. framing_err shows the bit of the entry at the head of the buffer. After a read it shows the bit of the next entry. A new start is accepted only after the line has returned high.
- R10: The buffer holds two words and delivers them oldest first. data_ready is 1 while it holds any word. A one-cycle host_rd pops one word. host_rd on an empty buffer has no effect. While the buffer is empty, rd_data, rd_bit9 and framing_err read 0.
- R11: A frame that would be stored while the buffer is full sets overrun_err and is lost. While overrun_err is set, no frame is stored, even after reads. overrun_err clears only when cont_rx_en is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| port_en | input | 1 | Serial port enable |
| nine_bit_en | input | 1 | 1 selects nine data bits, 0 selects eight |
| cont_rx_en | input | 1 | Continuous receive enable; 0 also clears overrun |
| addr_det_en | input | 1 | Address filter enable (nine-bit mode only) |
| host_rd | input | 1 | One-cycle strobe that pops the head word |
| rd_data | output | DATA_W | Data byte of the head word |
| rd_bit9 | output | 1 | Ninth bit of the head word |
| data_ready | output | 1 | Buffer holds at least one word |
| framing_err | output | 1 | Framing-error bit of the head word |
| overrun_err | output | 1 | Sticky overrun flag |

## Verification
The bench sends frames whose ninth bit is both set and clear with the address filter on and off. A design that ignored the mode bits, or filtered in eight-bit mode, would gain or lose words. A short low glitch comes before a real frame: a receiver that trusted the falling edge alone would shift in garbage and misalign the next byte. A bad stop bit is followed by a good frame, which shows whether the framing flag moves with the buffer head or is sticky or global. The overrun sequence reads after the overflow and sends once more. A design that reloaded while the flag was set, cleared it on a read or overwrote a held word would show the wrong word order or the wrong flag state.

// File: rtl/nbit_uart_rx_pkg.sv
// Shared types for the nine-bit serial receiver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package nbit_uart_rx_pkg;

    // Receiver sequencing states
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

endpackage

// File: rtl/nbit_uart_rx_sampler.sv
// Line synchroniser and frame sequencer.
// Confirms the start bit at mid-bit, then samples each data bit and the stop
// bit at the end of a further full bit time. It raises frame_done for one
// cycle with the assembled word.
// Assumes: tick pulses OVS times per bit and OVS is even; en low forces idle.
module nbit_uart_rx_sampler
    import nbit_uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              line_raw,
    input  logic              nine,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_b9,
    output logic              frame_ferr
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [1:0]      sync_q;
    logic            line;
    rx_state_t       state_q;
    logic [CW-1:0]   cnt_q;
    logic [IW-1:0]   idx_q;
    logic [IW-1:0]   last_idx;
    logic [DATA_W:0] shreg_q;
    logic            armed_q;

    assign line     = sync_q[1];
    assign last_idx = nine ? IW'(DATA_W) : IW'(DATA_W - 1);

    // Two-stage synchroniser for the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_raw};
    end

    // Frame sequencer: start check, data shifting, stop sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RX_IDLE;
            cnt_q      <= '0;
            idx_q      <= '0;
            shreg_q    <= '0;
            armed_q    <= 1'b0;
            frame_done <= 1'b0;
            frame_ferr <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (!en) begin
                state_q <= RX_IDLE;
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else if (tick) begin
                case (state_q)
                    RX_IDLE: begin
                        cnt_q <= '0;
                        if (line)         armed_q <= 1'b1;
                        else if (armed_q) state_q <= RX_START;
                    end
                    RX_START: begin
                        if (cnt_q == HALF) begin
                            cnt_q <= '0;
                            if (!line) begin
                                state_q <= RX_DATA;
                                idx_q   <= '0;
                                shreg_q <= '0;
                            end else begin
                                state_q <= RX_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q          <= '0;
                            shreg_q[idx_q] <= line;
                            if (idx_q == last_idx) state_q <= RX_STOP;
                            else                   idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt_q == LAST) begin
                            cnt_q      <= '0;
                            state_q    <= RX_IDLE;
                            armed_q    <= 1'b0;
                            frame_done <= 1'b1;
                            frame_ferr <= !line;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign frame_data = shreg_q[DATA_W-1:0];
    assign frame_b9   = shreg_q[DATA_W];

endmodule

// File: rtl/nbit_uart_rx_fifo.sv
// Small holding buffer, oldest entry presented at the head.
// A push is ignored when full and a pop is ignored when empty.
// Assumes: DEPTH is a power of two.
module nbit_uart_rx_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [LW-1:0] lvl_q;
    logic          do_push, do_pop;

    assign empty   = (lvl_q == '0);
    assign full    = (lvl_q == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[rd_q];
    assign level   = lvl_q;

    // Storage, pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= din;
                wr_q        <= wr_q + 1'b1;
            end
            if (do_pop) rd_q <= rd_q + 1'b1;
            lvl_q <= lvl_q + LW'(do_push) - LW'(do_pop);
        end
    end

endmodule

// File: rtl/nbit_uart_rx.sv
// Top of the nine-bit serial receiver.
// Applies the address filter to finished frames, loads accepted words into
// the holding buffer, keeps the sticky overrun flag and drives the head word
// onto the outputs, forced to zero while the buffer is empty.
// Assumes: baud_tick is generated outside at OVS ticks per bit.
module nbit_uart_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic              port_en,
    input  logic              nine_bit_en,
    input  logic              cont_rx_en,
    input  logic              addr_det_en,
    input  logic              host_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              data_ready,
    output logic              framing_err,
    output logic              overrun_err
);
    localparam int WW = DATA_W + 2;
    localparam int LW = $clog2(DEPTH + 1);

    logic              frame_done, frame_b9, frame_ferr;
    logic [DATA_W-1:0] frame_data;
    logic [WW-1:0]     head;
    logic              empty, full, wanted, push, ovr_q;
    logic [LW-1:0]     level;

    nbit_uart_rx_sampler #(.DATA_W(DATA_W), .OVS(OVS)) i_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (port_en && cont_rx_en),
        .tick       (baud_tick),
        .line_raw   (rx_line),
        .nine       (nine_bit_en),
        .frame_done (frame_done),
        .frame_data (frame_data),
        .frame_b9   (frame_b9),
        .frame_ferr (frame_ferr)
    );

    // Address filter drops nine-bit frames with a clear ninth bit
    assign wanted = frame_done && !(nine_bit_en && addr_det_en && !frame_b9);
    assign push   = wanted && !ovr_q && !full;

    nbit_uart_rx_fifo #(.W(WW), .DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({frame_ferr, frame_b9, frame_data}),
        .pop   (host_rd),
        .head  (head),
        .empty (empty),
        .full  (full),
        .level (level)
    );

    // Sticky overrun flag, cleared only by dropping continuous receive
    always_ff @(posedge clk) begin
        if (!rst_n)                           ovr_q <= 1'b0;
        else if (!cont_rx_en)                 ovr_q <= 1'b0;
        else if (wanted && !ovr_q && full)    ovr_q <= 1'b1;
    end

    assign data_ready  = !empty;
    assign rd_data     = empty ? '0 : head[DATA_W-1:0];
    assign rd_bit9     = !empty && head[DATA_W];
    assign framing_err = !empty && head[DATA_W+1];
    assign overrun_err = ovr_q;

endmodule

// File: rtl/nbit_uart_rx_chk.sv
// Property checker for the nine-bit serial receiver, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module nbit_uart_rx_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2,
    parameter int LW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic              cont_rx_en,
    input logic              nine_bit_en,
    input logic              addr_det_en,
    input logic              host_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_bit9,
    input logic              data_ready,
    input logic              framing_err,
    input logic              overrun_err,
    input logic              frame_done,
    input logic              frame_b9,
    input logic [LW-1:0]     level
);
    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    a_r10_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> (rd_data == '0 && !rd_bit9 && !framing_err));

    a_r10_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && data_ready && !frame_done) |=> level == $past(level) - 1'b1);

    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_err && cont_rx_en) |=> overrun_err);

    a_r11_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_rx_en |=> !overrun_err);

    a_r11_hold_while_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_err && !host_rd) |=> $stable(rd_data));

    a_r4_addr_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && nine_bit_en && addr_det_en && !frame_b9 && !host_rd)
        |=> $stable(level));

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !frame_done);

endmodule

bind nbit_uart_rx nbit_uart_rx_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LW(LW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_en     (port_en),
    .cont_rx_en  (cont_rx_en),
    .nine_bit_en (nine_bit_en),
    .addr_det_en (addr_det_en),
    .host_rd     (host_rd),
    .rd_data     (rd_data),
    .rd_bit9     (rd_bit9),
    .data_ready  (data_ready),
    .framing_err (framing_err),
    .overrun_err (overrun_err),
    .frame_done  (frame_done),
    .frame_b9    (frame_b9),
    .level       (level)
);

// File: tb/test_nbit_uart_rx.sv
`timescale 1ns/1ps
// Directed bench for the nine-bit serial receiver: one task per scenario.
module test_nbit_uart_rx;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       baud_tick = 1'b0;
    logic       port_en = 1'b0, nine_bit_en = 1'b0, cont_rx_en = 1'b0;
    logic       addr_det_en = 1'b0, host_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, data_ready, framing_err, overrun_err;
    logic [1:0] tdiv = '0;
    int         n_checks = 0, n_errors = 0;
    bit         finished = 1'b0;

    nbit_uart_rx i_nbit_uart_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
        .port_en(port_en), .nine_bit_en(nine_bit_en), .cont_rx_en(cont_rx_en),
        .addr_det_en(addr_det_en), .host_rd(host_rd), .rd_data(rd_data),
        .rd_bit9(rd_bit9), .data_ready(data_ready), .framing_err(framing_err),
        .overrun_err(overrun_err)
    );

    always #2.5 clk = ~clk;

    // Baud tick at one clock in TICK_DIV
    always @(posedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'(TICK_DIV - 1));
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int clocks);
        rx_line = v;
        repeat (clocks) @(negedge clk);
    endtask

    // Sends start, nbits data bits LSB first, stop, then an idle gap
    task automatic send(input logic [8:0] w, input int nbits, input logic stop);
        @(negedge clk);
        hold(1'b0, BIT_CLK);
        for (int i = 0; i < nbits; i++) hold(w[i], BIT_CLK);
        hold(stop, BIT_CLK);
        hold(1'b1, 2 * BIT_CLK);
    endtask

    task automatic pop();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic expect_head(input string req, input int d, input int b9, input int fe);
        @(negedge clk);
        chk(req, "data_ready", data_ready, 1);
        chk(req, "rd_data", rd_data, d);
        chk(req, "rd_bit9", rd_bit9, b9);
        chk(req, "framing_err", framing_err, fe);
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        chk(req, "data_ready", data_ready, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        port_en = 1'b1; cont_rx_en = 1'b1; nine_bit_en = 1'b0; addr_det_en = 1'b0;
        rx_line = 1'b1; host_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        hold(1'b1, 2 * BIT_CLK);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "data_ready", data_ready, 0);
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "rd_bit9", rd_bit9, 0);
        chk("R1", "framing_err", framing_err, 0);
        chk("R1", "overrun_err", overrun_err, 0);
    endtask

    task automatic t_eight_bit();
        do_reset();
        send(9'h1A5, 8, 1'b1);
        expect_head("R2", 8'hA5, 0, 0);
        pop();
        send(9'h03C, 8, 1'b1);
        expect_head("R2", 8'h3C, 0, 0);
        pop();
        expect_empty("R2");
    endtask

    task automatic t_nine_bit();
        do_reset();
        nine_bit_en = 1'b1;
        send(9'h15A, 9, 1'b1);
        expect_head("R3", 8'h5A, 1, 0);
        pop();
        send(9'h0FF, 9, 1'b1);
        expect_head("R3", 8'hFF, 0, 0);
        pop();
    endtask

    task automatic t_addr_filter();
        do_reset();
        nine_bit_en = 1'b1; addr_det_en = 1'b1;
        send(9'h011, 9, 1'b1);
        expect_empty("R4");
        send(9'h122, 9, 1'b1);
        expect_head("R4", 8'h22, 1, 0);
        pop();
        expect_empty("R4");
    endtask

    task automatic t_addr_off();
        do_reset();
        nine_bit_en = 1'b1; addr_det_en = 1'b0;
        send(9'h033, 9, 1'b1);
        send(9'h144, 9, 1'b1);
        expect_head("R5", 8'h33, 0, 0);
        pop();
        expect_head("R5", 8'h44, 1, 0);
        pop();
    endtask

    task automatic t_addr_eight();
        do_reset();
        nine_bit_en = 1'b0; addr_det_en = 1'b1;
        send(9'h066, 8, 1'b1);
        expect_head("R6", 8'h66, 0, 0);
        pop();
    endtask

    task automatic t_disabled();
        do_reset();
        port_en = 1'b0;
        send(9'h077, 8, 1'b1);
        expect_empty("R7");
        port_en = 1'b1; cont_rx_en = 1'b0;
        send(9'h078, 8, 1'b1);
        expect_empty("R7");
        cont_rx_en = 1'b1;
        hold(1'b1, BIT_CLK);
        send(9'h079, 8, 1'b1);
        expect_head("R7", 8'h79, 0, 0);
        pop();
    endtask

    task automatic t_glitch();
        do_reset();
        hold(1'b0, 4 * TICK_DIV);
        hold(1'b1, 2 * BIT_CLK);
        expect_empty("R8");
        send(9'h0C3, 8, 1'b1);
        expect_head("R8", 8'hC3, 0, 0);
        pop();
    endtask

    task automatic t_framing();
        do_reset();
        send(9'h055, 8, 1'b0);
        send(9'h0AA, 8, 1'b1);
        expect_head("R9", 8'h55, 0, 1);
        pop();
        expect_head("R9", 8'hAA, 0, 0);
        pop();
    endtask

    task automatic t_buffer();
        do_reset();
        pop();
        expect_empty("R10");
        send(9'h081, 8, 1'b1);
        send(9'h082, 8, 1'b1);
        chk("R10", "overrun_err", overrun_err, 0);
        expect_head("R10", 8'h81, 0, 0);
        pop();
        expect_head("R10", 8'h82, 0, 0);
        pop();
        expect_empty("R10");
        chk("R10", "rd_data empty", rd_data, 0);
    endtask

    task automatic t_overrun();
        do_reset();
        send(9'h091, 8, 1'b1);
        send(9'h092, 8, 1'b1);
        send(9'h093, 8, 1'b1);
        @(negedge clk);
        chk("R11", "overrun_err set", overrun_err, 1);
        expect_head("R11", 8'h91, 0, 0);
        pop();
        send(9'h094, 8, 1'b1);
        chk("R11", "overrun_err held", overrun_err, 1);
        expect_head("R11", 8'h92, 0, 0);
        pop();
        expect_empty("R11");
        cont_rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11", "overrun_err cleared", overrun_err, 0);
        cont_rx_en = 1'b1;
        hold(1'b1, BIT_CLK);
        send(9'h095, 8, 1'b1);
        expect_head("R11", 8'h95, 0, 0);
        pop();
    endtask

    initial begin
        t_reset();
        t_eight_bit();
        t_nine_bit();
        t_addr_filter();
        t_addr_off();
        t_addr_eight();
        t_disabled();
        t_glitch();
        t_framing();
        t_buffer();
        t_overrun();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule